// File: doc/BRIEF.md
# Color Palette Access Controller

This block holds a color lookup table of 256 entries, each 24 bits wide: one byte each for red, green and blue. A processor reaches the table through an 8-bit port with four register selects. One select loads the address for writing. One loads the address for reading. One moves palette data one color byte at a time. The last one holds the 6-bit mode flag. The processor does not present 24-bit words. It loads an address once and then streams color bytes in the order red, green, blue. A holding register gathers or hands out the bytes, and the address steps forward by itself after each full entry, so a block of entries can be loaded or dumped without further address writes.

A pixel port takes an 8-bit index every clock and returns the 24-bit color one cycle later. The color passes through a formatter. In 6-bit mode the formatter moves each channel's low six bits to the top and fills the two low bits with zero. Processor readback in 6-bit mode clears the two top bits of every byte. The table itself always keeps the full eight bits that were written.

The byte sequencing is a three-state machine with the states RED, GREEN and BLUE. There are three transitions. ADVANCE moves RED to GREEN and GREEN to BLUE on a data access. WRAP moves BLUE back to RED on a data access and moves an entry between the holding register and the table. RESTART forces RED on any address write.

Top module: `clut_palette_ctrl`

## Requirements
- R1: After reset the address register reads 0, the mode register reads 0 (8-bit mode), the byte sequencer is in RED, and the holding register is cleared, so the first three data reads return 0.
- R2: A write with `host_sel`=2'b00 loads the address register. A read with `host_sel` of 2'b00 or 2'b10 returns the address register's current value.
- R3: Data writes (`host_sel`=2'b01) take red, then green, then blue. The blue write stores {red, green, blue} at the current address, with red in bits 23:16 and blue in bits 7:0. The address increments after the blue write only.
- R4: Further byte triples with no new address write load consecutive entries, and the address wraps from 255 to 0.
- R5: A write with `host_sel`=2'b10 copies the entry at the written address into the holding register and sets the address to the written value plus one.
- R6: Data reads return red, green and blue from the holding register, in that order. After the blue read the entry at the current address is loaded into the holding register and the address increments, so reads stream through consecutive entries and wrap past 255.
- R7: A write to either address select in the middle of a byte triple returns the sequencer to RED. The partial triple is dropped and no entry is written.
- R8: With 6-bit mode on, every data read returns its byte with bits 7:6 cleared. All eight written bits stay stored and read back in full once 8-bit mode is selected again.
- R9: The pixel color for `pix_index` appears on `pix_color` one cycle later. In 8-bit mode it equals the stored entry. In 6-bit mode each channel c becomes {c[5:0], 2'b00}.
- R10: Processor accesses never delay or alter a pixel lookup. A lookup in the same cycle as the blue write to the same entry returns that entry's previous content.
- R11: A write with `host_sel`=2'b11 sets 6-bit mode from bit 0 of the written byte and ignores the other bits. A read of that select returns {7'b0, mode}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_sel | input | 2 | Register select: 00 write address, 01 data, 10 read address, 11 mode |
| host_wr | input | 1 | Processor write strobe, one access per cycle, takes priority over read |
| host_rd | input | 1 | Processor read strobe; advances the byte sequencer on data reads |
| host_wdata | input | 8 | Processor write byte |
| host_rdata | output | 8 | Processor read byte for the selected register |
| pix_index | input | 8 | Pixel lookup index |
| pix_color | output | 24 | Formatted pixel color {red, green, blue}, one cycle after the index |

## Verification
The bench goes after the points where the byte sequencer and the address counter meet. It covers address wrap during both a write stream and a read stream, and an address write that interrupts a half-finished triple. A counter that incremented on every byte, or that was not reset by address writes, would store colors at shifted entries or return green where red is due. It checks readback masking against the stored bits by leaving 6-bit mode and reading the same entry back in full, which catches a design that masks on the way in. It issues a pixel lookup in the same cycle as a blue write to the same entry, and a design that forwarded the new word or stalled the pixel path would return the wrong color there.

// File: rtl/clut_pkg.sv
package clut_pkg;

    // Processor register selects
    typedef enum logic [1:0] {
        SEL_WADDR = 2'b00,
        SEL_DATA  = 2'b01,
        SEL_RADDR = 2'b10,
        SEL_MODE  = 2'b11
    } host_sel_e;

    // Color byte sequencer states
    typedef enum logic [1:0] {
        PH_RED   = 2'b00,
        PH_GREEN = 2'b01,
        PH_BLUE  = 2'b10
    } phase_e;

endpackage

// File: rtl/clut_store.sv
module clut_store #(
    parameter int IDX_W  = 8,
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  hraddr,
    output logic [WORD_W-1:0] hrdata,
    input  logic [IDX_W-1:0]  pidx,
    output logic [WORD_W-1:0] pdata
);
    localparam int DEPTH = 1 << IDX_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Two independent read ports: holding-register loads and pixel lookups
    assign hrdata = mem[hraddr];
    assign pdata  = mem[pidx];

endmodule

// File: rtl/clut_pix_fmt.sv
module clut_pix_fmt #(
    parameter int CH_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode6,
    input  logic [3*CH_W-1:0] din,
    output logic [3*CH_W-1:0] pix_q
);
    localparam int NCH = 3;
    localparam int LO  = 2;

    logic [3*CH_W-1:0] fmt;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        assign fmt[ch*CH_W +: CH_W] = mode6
            ? {din[ch*CH_W +: CH_W-LO], {LO{1'b0}}}
            : din[ch*CH_W +: CH_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pix_q <= '0;
        end else begin
            pix_q <= fmt;
        end
    end

endmodule

// File: rtl/clut_host_seq.sv
module clut_host_seq
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          host_sel,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [CH_W-1:0]     host_wdata,
    output logic [CH_W-1:0]     host_rdata,
    output logic                mem_we,
    output logic [IDX_W-1:0]    mem_waddr,
    output logic [3*CH_W-1:0]   mem_wdata,
    output logic [IDX_W-1:0]    mem_raddr,
    input  logic [3*CH_W-1:0]   mem_rdata,
    output logic                mode6,
    output logic [IDX_W-1:0]    addr_q,
    output phase_e              phase_q
);
    localparam int WORD_W = 3 * CH_W;
    localparam int TOP_HI = 2;

    host_sel_e          sel;
    phase_e             phase_d;
    logic               waddr_op;
    logic               raddr_op;
    logic               data_wr;
    logic               data_rd;
    logic               mode_wr;
    logic               step;
    logic               wrap;
    logic [WORD_W-1:0]  hold_q;
    logic [CH_W-1:0]    cur_byte;
    logic [CH_W-1:0]    rd_mask;

    assign sel      = host_sel_e'(host_sel);
    assign waddr_op = host_wr && (sel == SEL_WADDR);
    assign raddr_op = host_wr && (sel == SEL_RADDR);
    assign data_wr  = host_wr && (sel == SEL_DATA);
    assign data_rd  = !host_wr && host_rd && (sel == SEL_DATA);
    assign mode_wr  = host_wr && (sel == SEL_MODE);
    assign step     = data_wr || data_rd;
    assign wrap     = step && (phase_q == PH_BLUE);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= PH_RED;
        end else begin
            phase_q <= phase_d;
        end
    end

    // Next state: RESTART, ADVANCE, WRAP
    always_comb begin
        phase_d = phase_q;
        if (waddr_op || raddr_op) begin
            phase_d = PH_RED;
        end else if (step) begin
            unique case (phase_q)
                PH_RED:   phase_d = PH_GREEN;
                PH_GREEN: phase_d = PH_BLUE;
                PH_BLUE:  phase_d = PH_RED;
                default:  phase_d = PH_RED;
            endcase
        end
    end

    // Outputs of the sequencer
    always_comb begin
        unique case (phase_q)
            PH_RED:   cur_byte = hold_q[2*CH_W +: CH_W];
            PH_GREEN: cur_byte = hold_q[CH_W +: CH_W];
            PH_BLUE:  cur_byte = hold_q[0 +: CH_W];
            default:  cur_byte = '0;
        endcase
        rd_mask   = mode6 ? {{TOP_HI{1'b0}}, {(CH_W-TOP_HI){1'b1}}} : '1;
        mem_we    = data_wr && (phase_q == PH_BLUE);
        mem_waddr = addr_q;
        mem_wdata = {hold_q[WORD_W-1 -: 2*CH_W], host_wdata};
        mem_raddr = raddr_op ? IDX_W'(host_wdata) : addr_q;
        unique case (sel)
            SEL_WADDR, SEL_RADDR: host_rdata = CH_W'(addr_q);
            SEL_DATA:             host_rdata = cur_byte & rd_mask;
            SEL_MODE:             host_rdata = CH_W'(mode6);
            default:              host_rdata = '0;
        endcase
    end

    // Address, holding and mode registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            hold_q <= '0;
            mode6  <= 1'b0;
        end else begin
            if (waddr_op) begin
                addr_q <= IDX_W'(host_wdata);
            end
            if (raddr_op) begin
                hold_q <= mem_rdata;
                addr_q <= IDX_W'(host_wdata) + 1'b1;
            end
            if (data_wr) begin
                unique case (phase_q)
                    PH_RED:   hold_q[2*CH_W +: CH_W] <= host_wdata;
                    PH_GREEN: hold_q[CH_W +: CH_W]   <= host_wdata;
                    PH_BLUE:  hold_q[0 +: CH_W]      <= host_wdata;
                    default:  hold_q <= hold_q;
                endcase
            end
            if (data_rd && wrap) begin
                hold_q <= mem_rdata;
            end
            if (wrap) begin
                addr_q <= addr_q + 1'b1;
            end
            if (mode_wr) begin
                mode6 <= host_wdata[0];
            end
        end
    end

endmodule

// File: rtl/clut_palette_ctrl.sv
module clut_palette_ctrl
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          host_sel,
    input  logic                host_wr,
    input  logic                host_rd,
    input  logic [CH_W-1:0]     host_wdata,
    output logic [CH_W-1:0]     host_rdata,
    input  logic [IDX_W-1:0]    pix_index,
    output logic [3*CH_W-1:0]   pix_color
);
    localparam int WORD_W = 3 * CH_W;

    logic               mem_we;
    logic [IDX_W-1:0]   mem_waddr;
    logic [WORD_W-1:0]  mem_wdata;
    logic [IDX_W-1:0]   mem_raddr;
    logic [WORD_W-1:0]  mem_rdata;
    logic [WORD_W-1:0]  pix_raw;
    logic               mode6;
    logic [IDX_W-1:0]   addr_q;
    phase_e             phase_q;

    clut_host_seq #(.IDX_W(IDX_W), .CH_W(CH_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .mem_we     (mem_we),
        .mem_waddr  (mem_waddr),
        .mem_wdata  (mem_wdata),
        .mem_raddr  (mem_raddr),
        .mem_rdata  (mem_rdata),
        .mode6      (mode6),
        .addr_q     (addr_q),
        .phase_q    (phase_q)
    );

    clut_store #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_store (
        .clk    (clk),
        .we     (mem_we),
        .waddr  (mem_waddr),
        .wdata  (mem_wdata),
        .hraddr (mem_raddr),
        .hrdata (mem_rdata),
        .pidx   (pix_index),
        .pdata  (pix_raw)
    );

    clut_pix_fmt #(.CH_W(CH_W)) u_fmt (
        .clk   (clk),
        .rst_n (rst_n),
        .mode6 (mode6),
        .din   (pix_raw),
        .pix_q (pix_color)
    );

endmodule

// File: rtl/clut_palette_chk.sv
module clut_palette_chk
    import clut_pkg::*;
#(
    parameter int IDX_W = 8,
    parameter int CH_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          host_sel,
    input  logic                host_wr,
    input  logic [CH_W-1:0]     host_wdata,
    input  logic [CH_W-1:0]     host_rdata,
    input  logic [IDX_W-1:0]    addr_q,
    input  phase_e              phase_q,
    input  logic                mode6,
    input  logic [3*CH_W-1:0]   pix_color
);

    // R1: reset leaves address, sequencer and mode cleared
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (addr_q == '0 && phase_q == PH_RED && !mode6));

    // R2: write-mode address load
    a_r2_addr_load: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'b00) |=> addr_q == IDX_W'($past(host_wdata)));

    // R3: blue data access increments the address
    a_r3_blue_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'b01 && phase_q == PH_BLUE)
        |=> addr_q == ($past(addr_q) + 1'b1));

    // R3: red and green data writes leave the address alone
    a_r3_no_early_inc: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'b01 && phase_q != PH_BLUE)
        |=> addr_q == $past(addr_q));

    // R5: read-mode address load sets address to value plus one
    a_r5_read_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'b10)
        |=> addr_q == (IDX_W'($past(host_wdata)) + 1'b1));

    // R7: any address write restarts the sequencer at red
    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && (host_sel == 2'b00 || host_sel == 2'b10)) |=> phase_q == PH_RED);

    // R8: data readback is masked in 6-bit mode
    a_r8_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (mode6 && host_sel == 2'b01) |-> host_rdata[CH_W-1 -: 2] == 2'b00);

    // R9: pixel low bits are zero after a 6-bit-mode lookup
    a_r9_pix_low: assert property (@(posedge clk) disable iff (!rst_n)
        mode6 |=> (pix_color[0 +: 2] == 2'b00 && pix_color[CH_W +: 2] == 2'b00
                   && pix_color[2*CH_W +: 2] == 2'b00));

    // R11: mode follows bit 0 of the mode write
    a_r11_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_sel == 2'b11) |=> mode6 == $past(host_wdata[0]));

endmodule

bind clut_palette_ctrl clut_palette_chk #(.IDX_W(IDX_W), .CH_W(CH_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_sel   (host_sel),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .addr_q     (addr_q),
    .phase_q    (phase_q),
    .mode6      (mode6),
    .pix_color  (pix_color)
);

// File: tb/test_clut_palette_ctrl.sv
module test_clut_palette_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  host_sel = 2'b00;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = 8'h00;
    logic [7:0]  host_rdata;
    logic [7:0]  pix_index = 8'h00;
    logic [23:0] pix_color;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [23:0] exp_mem [256];
    logic [7:0]  m_addr = 8'h00;
    logic [23:0] m_hold = 24'h0;
    bit          m_six = 1'b0;

    logic [23:0] pix_exp_q [$];
    bit          pix_armed = 1'b0;

    always #5 clk = ~clk;

    clut_palette_ctrl i_clut_palette_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sel   (host_sel),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pix_index  (pix_index),
        .pix_color  (pix_color)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] fmt6(input logic [23:0] w);
        return {w[21:16], 2'b00, w[13:8], 2'b00, w[5:0], 2'b00};
    endfunction

    // One processor write per cycle, starting at a falling edge
    task automatic hwrite(input logic [1:0] sel, input logic [7:0] d);
        host_sel = sel; host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic hread(input logic [1:0] sel, output logic [7:0] d);
        host_sel = sel; host_rd = 1'b1;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic wr_addr(input logic [7:0] a);
        hwrite(2'b00, a);
        m_addr = a;
    endtask

    task automatic rd_addr(input logic [7:0] a);
        hwrite(2'b10, a);
        m_hold = exp_mem[a];
        m_addr = a + 8'd1;
    endtask

    task automatic put_rgb(input logic [7:0] r, input logic [7:0] g, input logic [7:0] b);
        hwrite(2'b01, r);
        hwrite(2'b01, g);
        hwrite(2'b01, b);
        exp_mem[m_addr] = {r, g, b};
        m_addr = m_addr + 8'd1;
    endtask

    task automatic get_rgb(input string tag);
        logic [7:0] d;
        logic [7:0] mask;
        mask = m_six ? 8'h3F : 8'hFF;
        hread(2'b01, d); chk({tag, " red"},   {24'h0, d}, {24'h0, m_hold[23:16] & mask});
        hread(2'b01, d); chk({tag, " green"}, {24'h0, d}, {24'h0, m_hold[15:8] & mask});
        hread(2'b01, d); chk({tag, " blue"},  {24'h0, d}, {24'h0, m_hold[7:0] & mask});
        m_hold = exp_mem[m_addr];
        m_addr = m_addr + 8'd1;
    endtask

    task automatic chk_addr(input string tag);
        logic [7:0] d;
        hread(2'b00, d);
        chk(tag, {24'h0, d}, {24'h0, m_addr});
    endtask

    // Scoreboard driver side: arm a lookup without consuming time
    task automatic pix_arm(input logic [7:0] idx);
        pix_index = idx;
        pix_exp_q.push_back(m_six ? fmt6(exp_mem[idx]) : exp_mem[idx]);
        pix_armed = 1'b1;
    endtask

    task automatic pix_req(input logic [7:0] idx);
        pix_arm(idx);
        @(negedge clk);
    endtask

    // Scoreboard monitor: a lookup captured at a rising edge is compared
    // after the following falling edge
    initial begin
        forever begin
            bit took;
            logic [23:0] e;
            @(posedge clk);
            took = pix_armed;
            pix_armed = 1'b0;
            @(negedge clk);
            #2;
            if (took) begin
                e = pix_exp_q.pop_front();
                chk("R9/R10 pixel", {8'h0, pix_color}, {8'h0, e});
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        for (int i = 0; i < 256; i++) exp_mem[i] = 24'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        hread(2'b00, d); chk("R1 address", {24'h0, d}, 32'h0);
        hread(2'b11, d); chk("R1 mode", {24'h0, d}, 32'h0);
        hread(2'b01, d); chk("R1 hold red", {24'h0, d}, 32'h0);
        hread(2'b01, d); chk("R1 hold green", {24'h0, d}, 32'h0);
        hread(2'b01, d); chk("R1 hold blue", {24'h0, d}, 32'h0);
        m_addr = 8'h01;
        chk_addr("R1 address after first triple");

        // R2: address load and readback through both selects
        wr_addr(8'h10);
        hread(2'b00, d); chk("R2 write-mode select", {24'h0, d}, 32'h10);
        hread(2'b10, d); chk("R2 read-mode select", {24'h0, d}, 32'h10);

        // R3: byte order and increment after blue only
        hwrite(2'b01, 8'h12); chk_addr("R3 after red");
        hwrite(2'b01, 8'h34); chk_addr("R3 after green");
        hwrite(2'b01, 8'h56);
        exp_mem[8'h10] = 24'h123456; m_addr = 8'h11;
        chk_addr("R3 after blue");

        // R4: consecutive entries and wrap
        put_rgb(8'h9A, 8'hBC, 8'hDE);
        put_rgb(8'h01, 8'h23, 8'h45);
        chk_addr("R4 consecutive");
        wr_addr(8'hFE);
        put_rgb(8'h77, 8'h66, 8'h55);
        put_rgb(8'hA1, 8'hB2, 8'hC3);
        chk_addr("R4 wrap to zero");
        put_rgb(8'h0F, 8'h1E, 8'h2D);

        // R5 and R6: read-mode load and streaming reads
        rd_addr(8'h10);
        chk_addr("R5 address plus one");
        get_rgb("R5 entry 10");
        get_rgb("R6 stream entry 11");
        get_rgb("R6 stream entry 12");
        chk_addr("R6 address after stream");
        rd_addr(8'hFE);
        get_rgb("R6 entry FE");
        get_rgb("R6 entry FF");
        chk_addr("R6 read wrap");
        get_rgb("R6 entry 00 after wrap");

        // R7: address write mid-triple restarts the sequence
        wr_addr(8'h20);
        hwrite(2'b01, 8'hAA);
        wr_addr(8'h20);
        put_rgb(8'h01, 8'h02, 8'h03);
        chk_addr("R7 no extra entry");
        rd_addr(8'h20);
        get_rgb("R7 restarted write");
        rd_addr(8'h10);
        hread(2'b01, d); chk("R7 first red", {24'h0, d}, 32'h12);
        rd_addr(8'h10);
        get_rgb("R7 restarted read");

        // R11: mode register, only bit 0 counts
        hwrite(2'b11, 8'hFE);
        hread(2'b11, d); chk("R11 bit0 only", {24'h0, d}, 32'h0);
        hwrite(2'b11, 8'h01); m_six = 1'b1;
        hread(2'b11, d); chk("R11 6-bit set", {24'h0, d}, 32'h1);

        // R8: masked readback, full storage
        wr_addr(8'h30);
        put_rgb(8'hFF, 8'hC3, 8'h81);
        rd_addr(8'h30);
        get_rgb("R8 masked readback");
        hwrite(2'b11, 8'h00); m_six = 1'b0;
        rd_addr(8'h30);
        get_rgb("R8 full bits kept");

        // R9: pixel path in both modes
        pix_req(8'h10);
        pix_req(8'h30);
        pix_req(8'hFF);
        hwrite(2'b11, 8'h01); m_six = 1'b1;
        pix_req(8'h30);
        pix_req(8'h10);
        hwrite(2'b11, 8'h00); m_six = 1'b0;
        @(negedge clk);

        // R10: lookup during blue write of the same entry sees the old word
        wr_addr(8'h40);
        put_rgb(8'h0A, 8'h0B, 8'h0C);
        wr_addr(8'h40);
        hwrite(2'b01, 8'h11);
        hwrite(2'b01, 8'h22);
        pix_arm(8'h40);
        hwrite(2'b01, 8'h33);
        exp_mem[8'h40] = 24'h112233; m_addr = 8'h41;
        pix_req(8'h40);
        // R10: lookups stream while the processor reads
        pix_arm(8'h11);
        rd_addr(8'h11);
        pix_arm(8'h12);
        hread(2'b01, d); chk("R10 host red beside pixel", {24'h0, d}, 32'h9A);
        pix_arm(8'h40);
        hread(2'b01, d); chk("R10 host green beside pixel", {24'h0, d}, 32'hBC);
        repeat (3) @(negedge clk);
        chk("R10 scoreboard drained", pix_exp_q.size(), 32'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule